// File: doc/BRIEF.md
# UART Channel Register Bank and Interrupt Identifier

This block is the host-facing side of one serial channel. A host drives a 3-bit address with a read or write strobe. The block turns each access into a read or an update of the channel's control, status, divisor and scratch registers. Bit 7 of the line control register is a bank bit. When the bank bit is set, the three lowest addresses reach the divisor latch bytes and an alternate-function register instead of the data, interrupt-enable and identification/FIFO-control locations.

The serial engine and the FIFOs stay outside the block. It receives their flags: data ready, one-cycle line-error events, holding-register empty, transmitter idle and the four modem input pins. It returns strobes to pop the receive FIFO, push into the transmit path and clear either FIFO. Four interrupt sources are tracked. Each is cleared only by the register access that belongs to it. The identification register reports the most urgent enabled source, and one interrupt line is driven.

Top module: `uart_regbank`

## Requirements
- R1: With line-control bit 7 set, address 0 reads and writes the divisor low byte, address 1 the divisor high byte and address 2 the alternate-function register. `divisor` outputs {high, low}.
- R2: With line-control bit 7 clear, a read at address 0 returns `rx_data` and pulses `rx_pop` in that cycle. A write there pulses `tx_push` with `tx_data` equal to `wdata`. Address 1 holds interrupt enables in bits 3:0 (0 data, 1 holding empty, 2 line status, 3 modem status), and bits 7:4 read as 0.
- R3: With bit 7 clear, address 2 reads the identification register and writes FIFO control, which cannot be read back. Control bit 0 drives `fifo_en` and identification bits 7:6, and control bits 7:6 drive `rx_trig`.
- R4: Whatever the bank bit, addresses 3 to 7 select line control (8 bits), modem control (bits 4:0, upper bits read 0), line status, modem status and scratch. Writes to addresses 5 and 6 have no effect.
- R5: Synchronous reset clears interrupt enables, FIFO control, line control, modem control, scratch, both divisor bytes and the alternate-function register. The identification register then reads 0x01 and `irq` is low.
- R6: Line status is {any latched error, `tx_idle`, `thr_empty`, latched errors[3:0], `rx_ready`}, where `line_err` bits 0..3 (overrun, parity, framing, break) latch into status bits 1..4. A line-status read clears the latched bits.
- R7: Modem status bits 7:4 show `modem_in` (0 CTS, 1 DSR, 2 RI, 3 DCD). Delta bits 0, 1 and 3 latch on any change of their pin. Bit 2 latches only on a falling RI. A modem-status read clears the deltas.
- R8: Identification bit 0 is 0 exactly when an enabled source is pending. Bits 3:1 give the highest-priority source: 011 line status, 010 received data, 001 holding empty, 000 modem status. Bits 5:4 read 0, and `irq` is high while any enabled source pends.
- R9: The holding-empty source becomes pending when `thr_empty` rises or when its enable is turned on while `thr_empty` is high. It clears on a holding-register write, or on an identification read that reports it.
- R10: The line-status source clears on a line-status read and the modem source on a modem-status read. The data source follows `rx_ready`.
- R11: One cycle after a FIFO-control write with bits 1 and 0 set, `rx_fifo_clr` is high for one cycle; bits 2 and 0 do the same for `tx_fifo_clr`. Bit 1 or 2 without bit 0 clears nothing. Both clears are high while reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| addr | input | 3 | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| rx_data | input | 8 | Head of the receive FIFO |
| rx_ready | input | 1 | Receive data available |
| rx_pop | output | 1 | Pop receive FIFO |
| tx_data | output | 8 | Byte to transmit |
| tx_push | output | 1 | Push byte into the transmit path |
| thr_empty | input | 1 | Transmit holding register empty |
| tx_idle | input | 1 | Transmitter fully idle |
| line_err | input | 4 | One-cycle error events: overrun, parity, framing, break |
| modem_in | input | 4 | Modem pins: CTS, DSR, RI, DCD |
| rx_fifo_clr | output | 1 | Clear receive FIFO |
| tx_fifo_clr | output | 1 | Clear transmit FIFO |
| fifo_en | output | 1 | FIFO mode enable |
| rx_trig | output | 2 | Receive trigger level select |
| line_ctrl | output | 8 | Line control register |
| modem_ctrl | output | 5 | Modem control register |
| divisor | output | 16 | Baud divisor |
| alt_func | output | 8 | Alternate-function register |
| irq | output | 1 | Interrupt request |

## Verification
The register map is swept four times over both bank settings. Each round writes a distinct arithmetic pattern to every address and then reads all eight back. This separates banked aliasing, ignored status writes, masked upper bits and the FIFO-control/identification split. Interrupts are raised one on top of another and then retired one clearing access at a time, so a wrong priority or a wrong clearing access shows up as a wrong identification code. The modem pins are stepped through falling and rising RI and a DCD change to tell the edge rules apart. FIFO-control writes with bit 0 present or absent show which clear pulse, if any, follows.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int NSRC  = 4;
    localparam int NSEL  = 11;
    localparam int SELW  = $clog2(NSEL);
    localparam int MCW   = 5;

    typedef enum logic [SELW-1:0] {
        SEL_DATA, SEL_IEN, SEL_IDF, SEL_LCTL, SEL_MCTL, SEL_LSTAT,
        SEL_MSTAT, SEL_SCR, SEL_DIVL, SEL_DIVH, SEL_ALT
    } sel_e;

    typedef struct packed {
        logic mdm;
        logic line;
        logic tx;
        logic rx;
    } ien_t;

    localparam logic [2:0] ID_LINE = 3'b011;
    localparam logic [2:0] ID_RX   = 3'b010;
    localparam logic [2:0] ID_TX   = 3'b001;
    localparam logic [2:0] ID_MDM  = 3'b000;

    function automatic sel_e map_sel(input logic [AW-1:0] a, input logic bank);
        case (a)
            3'd0:    return bank ? SEL_DIVL : SEL_DATA;
            3'd1:    return bank ? SEL_DIVH : SEL_IEN;
            3'd2:    return bank ? SEL_ALT  : SEL_IDF;
            3'd3:    return SEL_LCTL;
            3'd4:    return SEL_MCTL;
            3'd5:    return SEL_LSTAT;
            3'd6:    return SEL_MSTAT;
            default: return SEL_SCR;
        endcase
    endfunction

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
    import uart_regbank_pkg::*;
(
    input  logic [AW-1:0]   addr,
    input  logic            bank,
    input  logic            rd,
    input  logic            wr,
    output sel_e            cur_sel,
    output logic [NSEL-1:0] rd_hit,
    output logic [NSEL-1:0] wr_hit
);
    assign cur_sel = map_sel(addr, bank);

    for (genvar g = 0; g < NSEL; g++) begin : g_hit
        assign rd_hit[g] = rd && (cur_sel == sel_e'(SELW'(g)));
        assign wr_hit[g] = wr && (cur_sel == sel_e'(SELW'(g)));
    end
endmodule

// File: rtl/uart_rb_status.sv
module uart_rb_status
    import uart_regbank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] line_err,
    input  logic            rx_ready,
    input  logic            thr_empty,
    input  logic            tx_idle,
    input  logic [NSRC-1:0] mdm_in,
    input  logic            lsr_rd,
    input  logic            msr_rd,
    output logic [DW-1:0]   lsr,
    output logic [DW-1:0]   msr
);
    logic [NSRC-1:0] err_q, dlt_q, pins_q, evt;

    // RI (pin 2) only counts its falling edge; other pins count any change
    always_comb begin
        evt    = pins_q ^ mdm_in;
        evt[2] = pins_q[2] & ~mdm_in[2];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= '0;
            dlt_q  <= '0;
            pins_q <= mdm_in;
        end else begin
            pins_q <= mdm_in;
            // events arriving in the clearing cycle survive the read
            err_q  <= lsr_rd ? line_err : (err_q | line_err);
            dlt_q  <= msr_rd ? evt      : (dlt_q | evt);
        end
    end

    assign lsr = {|err_q, tx_idle, thr_empty, err_q, rx_ready};
    assign msr = {mdm_in, dlt_q};
endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
    import uart_regbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ien_t       ien,
    input  logic       line_src,
    input  logic       rx_src,
    input  logic       thr_empty,
    input  logic       mdm_src,
    input  logic       id_rd,
    input  logic       thr_wr,
    output logic [3:0] ident,
    output logic       irq
);
    logic            thr_q, en_tx_q, tx_pend, any;
    logic [2:0]      code;
    logic [NSRC-1:0] act;

    always_comb begin
        act  = {mdm_src & ien.mdm, tx_pend & ien.tx, rx_src & ien.rx, line_src & ien.line};
        any  = |act;
        if (act[0])      code = ID_LINE;
        else if (act[1]) code = ID_RX;
        else if (act[2]) code = ID_TX;
        else             code = ID_MDM;
    end

    wire tx_set = thr_empty & (~thr_q | (ien.tx & ~en_tx_q));
    wire tx_clr = thr_wr | (id_rd & any & (code == ID_TX));

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q   <= thr_empty;
            en_tx_q <= 1'b0;
            tx_pend <= 1'b0;
        end else begin
            thr_q   <= thr_empty;
            en_tx_q <= ien.tx;
            if (tx_clr)      tx_pend <= 1'b0;
            else if (tx_set) tx_pend <= 1'b1;
        end
    end

    assign ident = {code, ~any};
    assign irq   = any;
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   addr,
    input  logic            rd,
    input  logic            wr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [DW-1:0]   rx_data,
    input  logic            rx_ready,
    output logic            rx_pop,
    output logic [DW-1:0]   tx_data,
    output logic            tx_push,
    input  logic            thr_empty,
    input  logic            tx_idle,
    input  logic [NSRC-1:0] line_err,
    input  logic [NSRC-1:0] modem_in,
    output logic            rx_fifo_clr,
    output logic            tx_fifo_clr,
    output logic            fifo_en,
    output logic [1:0]      rx_trig,
    output logic [DW-1:0]   line_ctrl,
    output logic [MCW-1:0]  modem_ctrl,
    output logic [2*DW-1:0] divisor,
    output logic [DW-1:0]   alt_func,
    output logic            irq
);
    sel_e            cur_sel;
    logic [NSEL-1:0] rd_hit, wr_hit;
    ien_t            ien;
    logic [DW-1:0]   scr, div_lo, div_hi, lsr, msr;
    logic [3:0]      ident;

    uart_rb_decode u_dec (
        .addr(addr), .bank(line_ctrl[DW-1]), .rd(rd), .wr(wr),
        .cur_sel(cur_sel), .rd_hit(rd_hit), .wr_hit(wr_hit)
    );

    uart_rb_status u_stat (
        .clk(clk), .rst(rst), .line_err(line_err), .rx_ready(rx_ready),
        .thr_empty(thr_empty), .tx_idle(tx_idle), .mdm_in(modem_in),
        .lsr_rd(rd_hit[SEL_LSTAT]), .msr_rd(rd_hit[SEL_MSTAT]),
        .lsr(lsr), .msr(msr)
    );

    uart_rb_irq u_irq (
        .clk(clk), .rst(rst), .ien(ien),
        .line_src(|lsr[4:1]), .rx_src(rx_ready), .thr_empty(thr_empty),
        .mdm_src(|msr[3:0]), .id_rd(rd_hit[SEL_IDF]), .thr_wr(wr_hit[SEL_DATA]),
        .ident(ident), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ien         <= '0;
            line_ctrl   <= '0;
            modem_ctrl  <= '0;
            scr         <= '0;
            div_lo      <= '0;
            div_hi      <= '0;
            alt_func    <= '0;
            fifo_en     <= 1'b0;
            rx_trig     <= '0;
            rx_fifo_clr <= 1'b1;
            tx_fifo_clr <= 1'b1;
        end else begin
            rx_fifo_clr <= wr_hit[SEL_IDF] & wdata[0] & wdata[1];
            tx_fifo_clr <= wr_hit[SEL_IDF] & wdata[0] & wdata[2];
            if (wr_hit[SEL_IEN])  ien        <= ien_t'(wdata[NSRC-1:0]);
            if (wr_hit[SEL_LCTL]) line_ctrl  <= wdata;
            if (wr_hit[SEL_MCTL]) modem_ctrl <= wdata[MCW-1:0];
            if (wr_hit[SEL_SCR])  scr        <= wdata;
            if (wr_hit[SEL_DIVL]) div_lo     <= wdata;
            if (wr_hit[SEL_DIVH]) div_hi     <= wdata;
            if (wr_hit[SEL_ALT])  alt_func   <= wdata;
            if (wr_hit[SEL_IDF]) begin
                fifo_en <= wdata[0];
                rx_trig <= wdata[7:6];
            end
        end
    end

    always_comb begin
        case (cur_sel)
            SEL_DATA:  rdata = rx_data;
            SEL_IEN:   rdata = {{(DW-NSRC){1'b0}}, ien};
            SEL_IDF:   rdata = {fifo_en, fifo_en, 2'b00, ident};
            SEL_LCTL:  rdata = line_ctrl;
            SEL_MCTL:  rdata = {{(DW-MCW){1'b0}}, modem_ctrl};
            SEL_LSTAT: rdata = lsr;
            SEL_MSTAT: rdata = msr;
            SEL_SCR:   rdata = scr;
            SEL_DIVL:  rdata = div_lo;
            SEL_DIVH:  rdata = div_hi;
            SEL_ALT:   rdata = alt_func;
            default:   rdata = '0;
        endcase
    end

    assign rx_pop  = rd_hit[SEL_DATA];
    assign tx_push = wr_hit[SEL_DATA];
    assign tx_data = wdata;
    assign divisor = {div_hi, div_lo};
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  addr,
    input logic        rd,
    input logic        wr,
    input logic [7:0]  wdata,
    input logic [7:0]  rdata,
    input logic [7:0]  line_ctrl,
    input logic        irq,
    input logic        rx_fifo_clr,
    input logic        tx_fifo_clr,
    input logic [15:0] divisor
);
    p_lcr_write_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 3'd3) |=> (line_ctrl == $past(wdata)));

    p_div_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!wr) |=> $stable(divisor));

    p_rx_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 3'd2 && !line_ctrl[7] && wdata[1] && wdata[0]) |=> rx_fifo_clr);

    p_tx_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 3'd2 && !line_ctrl[7] && wdata[2] && wdata[0]) |=> tx_fifo_clr);

    p_idle_bit_r8: assert property (@(posedge clk) disable iff (rst)
        (addr == 3'd2 && !line_ctrl[7]) |-> (rdata[0] == !irq));

    p_id_gap_r8: assert property (@(posedge clk) disable iff (rst)
        (addr == 3'd2 && !line_ctrl[7]) |-> (rdata[5:4] == 2'b00));

    p_quiet_after_reset_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !irq);
endmodule

bind uart_regbank uart_regbank_chk u_chk (.*);

// File: tb/uart_regbank_tb.sv
`timescale 1ns/1ps
module uart_regbank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [7:0]  wdata = '0, rdata, rx_data = 8'hA5, tx_data, line_ctrl, alt_func;
    logic        rx_ready = 1'b0, rx_pop, tx_push, thr_empty = 1'b1, tx_idle = 1'b1;
    logic [3:0]  line_err = '0, modem_in = 4'b0101;
    logic        rx_fifo_clr, tx_fifo_clr, fifo_en, irq;
    logic [1:0]  rx_trig;
    logic [4:0]  modem_ctrl;
    logic [15:0] divisor;

    int n_run = 0, n_fail = 0;
    logic pop_seen, push_seen;
    logic [7:0] push_val, d;

    always #2 clk = ~clk;

    uart_regbank u_dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd = 1'b1;
        #1 v = rdata; pop_seen = rx_pop;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk); addr = a; wdata = v; wr = 1'b1;
        #1 push_seen = tx_push; push_val = tx_data;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic done();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        done();
    end

    initial begin
        logic [7:0] ier_m, lcr_m, scr_m, dll_m, dlm_m, afr_m, exp_v;
        logic [4:0] mcr_m;
        logic       fe_m;
        repeat (3) @(negedge clk);
        chk("R11 rx clear in reset", rx_fifo_clr, 1);
        chk("R11 tx clear in reset", tx_fifo_clr, 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R5 irq after reset", irq, 0);
        rd_reg(3'd1, d); chk("R5 enables", d, 8'h00);
        rd_reg(3'd2, d); chk("R5 ident", d, 8'h01);
        rd_reg(3'd3, d); chk("R5 line ctrl", d, 8'h00);
        rd_reg(3'd4, d); chk("R5 modem ctrl", d, 8'h00);
        rd_reg(3'd5, d); chk("R6 status at reset", d, 8'h60);
        rd_reg(3'd6, d); chk("R7 modem status at reset", d, 8'h50);
        rd_reg(3'd7, d); chk("R5 scratch", d, 8'h00);
        chk("R5 divisor", divisor, 0);
        chk("R5 alt func", alt_func, 0);

        ier_m = 0; scr_m = 0; dll_m = 0; dlm_m = 0; afr_m = 0; mcr_m = 0; fe_m = 0;
        for (int r = 0; r < 4; r++) begin
            for (int b = 0; b < 2; b++) begin
                lcr_m = {b[0], 7'((r * 9 + 5) & 8'h7f)};
                wr_reg(3'd3, lcr_m);
                for (int a = 0; a < 8; a++) begin
                    logic [7:0] p;
                    if (a == 3) continue;
                    p = 8'((r * 53 + b * 29 + a * 17 + 11) & 255);
                    if (a == 1 && b == 0) p = p & 8'hF0;
                    wr_reg(3'(a), p);
                    case (a)
                        0: begin
                            chk("R2 push strobe", push_seen, b == 0);
                            if (b == 0) chk("R2 push data", push_val, p); else dll_m = p;
                        end
                        1: if (b == 0) ier_m = {4'h0, p[3:0]}; else dlm_m = p;
                        2: if (b == 0) begin
                               fe_m = p[0];
                               chk("R11 rx clear", rx_fifo_clr, p[0] & p[1]);
                               chk("R11 tx clear", tx_fifo_clr, p[0] & p[2]);
                               chk("R3 trigger", rx_trig, p[7:6]);
                           end else afr_m = p;
                        4: mcr_m = p[4:0];
                        7: scr_m = p;
                        default: ;
                    endcase
                end
                for (int a = 0; a < 8; a++) begin
                    rd_reg(3'(a), d);
                    case (a)
                        0: exp_v = b ? dll_m : 8'hA5;
                        1: exp_v = b ? dlm_m : ier_m;
                        2: exp_v = b ? afr_m : {fe_m, fe_m, 6'b000001};
                        3: exp_v = lcr_m;
                        4: exp_v = {3'b000, mcr_m};
                        5: exp_v = 8'h60;
                        6: exp_v = {modem_in, 4'h0};
                        default: exp_v = scr_m;
                    endcase
                    chk($sformatf("R1 R2 R3 R4 sweep r%0d bank%0d addr%0d", r, b, a), d, exp_v);
                    if (a == 0) chk("R2 pop strobe", pop_seen, b == 0);
                end
                chk("R1 divisor out", divisor, {dlm_m, dll_m});
                chk("R3 fifo enable", fifo_en, fe_m);
            end
        end

        wr_reg(3'd3, 8'h03);
        wr_reg(3'd2, 8'h02);
        chk("R11 bit1 alone", rx_fifo_clr, 0);
        wr_reg(3'd2, 8'h03);
        chk("R11 rx clear", rx_fifo_clr, 1);
        chk("R11 no tx clear", tx_fifo_clr, 0);
        wr_reg(3'd2, 8'h05);
        chk("R11 tx clear", tx_fifo_clr, 1);
        chk("R11 no rx clear", rx_fifo_clr, 0);
        @(negedge clk);
        chk("R11 single pulse", tx_fifo_clr, 0);

        wr_reg(3'd1, 8'h00);
        wr_reg(3'd1, 8'h02);
        @(negedge clk);
        chk("R9 enable while empty", irq, 1);
        rd_reg(3'd2, d); chk("R9 ident tx", d, 8'hC2);
        chk("R9 cleared by ident read", irq, 0);
        rd_reg(3'd2, d); chk("R8 ident idle", d, 8'hC1);
        @(negedge clk) thr_empty = 1'b0;
        @(negedge clk) thr_empty = 1'b1;
        @(negedge clk);
        chk("R9 empty rising", irq, 1);
        wr_reg(3'd0, 8'h5A);
        chk("R9 cleared by holding write", irq, 0);

        wr_reg(3'd1, 8'h0F);
        @(negedge clk) thr_empty = 1'b0;
        @(negedge clk) thr_empty = 1'b1; modem_in = 4'b0100; rx_ready = 1'b1; line_err = 4'b0010;
        @(negedge clk) line_err = 4'b0000;
        @(negedge clk);
        rd_reg(3'd2, d); chk("R8 line first", d, 8'hC6);
        rd_reg(3'd5, d); chk("R6 status with parity", d, 8'hE5);
        rd_reg(3'd5, d); chk("R10 status read clears", d, 8'h61);
        rd_reg(3'd2, d); chk("R8 data second", d, 8'hC4);
        @(negedge clk) rx_ready = 1'b0;
        rd_reg(3'd2, d); chk("R10 data follows ready", d, 8'hC2);
        rd_reg(3'd2, d); chk("R8 modem last", d, 8'hC0);
        rd_reg(3'd6, d); chk("R7 cts delta", d, 8'h41);
        rd_reg(3'd2, d); chk("R10 modem read clears", d, 8'hC1);

        @(negedge clk) modem_in = 4'b0000;
        @(negedge clk);
        chk("R7 ri fall raises irq", irq, 1);
        rd_reg(3'd6, d); chk("R7 ri falling", d, 8'h04);
        @(negedge clk) modem_in = 4'b0100;
        @(negedge clk);
        chk("R7 ri rise no irq", irq, 0);
        rd_reg(3'd6, d); chk("R7 ri rising ignored", d, 8'h40);
        @(negedge clk) modem_in = 4'b1100;
        @(negedge clk);
        rd_reg(3'd6, d); chk("R7 dcd delta", d, 8'hC8);
        chk("R8 idle at end", irq, 0);
        done();
    end
endmodule